// File: doc/BRIEF.md
# Programmable 64-bit Interval Timer

This block is a memory-mapped interval timer with a 64-bit count and a register port that is `DATA_W` bits wide (32 by default). Software stops and clears it, loads a 64-bit period in two halves, picks a count source and a divider, and then starts it. Each advance of the timer raises the count by one. When the count equals the programmed period, a period event occurs. In continuous mode the count wraps to zero and the timer carries on. In one-shot mode it stops. A pending flag records the event, and the interrupt line is that flag gated by an enable bit.

The timer advances from one of two sources. One is every bus clock cycle. The other is a synchronous strobe `alt_tick`, which stands in for a slower clock. The chosen source is divided by a 4-bit value D, giving one advance per D+1 source pulses. Two registers let software read the 64-bit count coherently: reading the low word captures the high word into a holding register, and a later read of the high word returns the captured value. The register port is a plain strobe interface with no handshake. `rdata` is a combinational decode of `addr`, and read side effects take place on the clock edge where `rd_en` is high.

Top module: `interval_timer64`

## Requirements
- R1: After hardware reset all registers read zero and `irq` is low. Writing control with bit 8 set stops the timer and clears the count, the count-high holding register, the interrupt enable and the pending flag. Mode and period keep their values. Bit 8 wins over bit 0 in the same write.
- R2: Byte offsets are control 0x00, mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, count low 0x20 and count high 0x24. Control reads back the running state in bit 0, and enable and status use bit 0.
- R3: A control write with bit 0 set clears the count and the divider and starts the timer. With divider D in mode bits 11:8 and period N, the first event comes (D+1)(N+1) source pulses after the start, and the count never exceeds N while running.
- R4: With mode bit 0 = 1 (continuous), an event returns the count to zero, the timer keeps running, and events repeat every (D+1)(N+1) source pulses.
- R5: With mode bit 0 = 0 (one-shot), an event stops the timer with the count at zero, and control bit 0 then reads 0.
- R6: Mode bit 3 = 1 makes `alt_tick` the only count source, so bus clock cycles without a strobe do not advance the count. Mode bit 3 = 0 counts every bus clock cycle.
- R7: A write to period high only stages the value. The following write to period low loads the full period {staged high, low} in one step.
- R8: A count-low read captures the count's upper word, and a later count-high read returns that captured word, so the two reads form one coherent 64-bit value however far apart they are.
- R9: `irq` is high exactly while the pending flag and enable bit 0 are both set. An event with the enable clear still sets the flag.
- R10: A status read clears the pending flag. If an event lands on the same edge as the read, the flag stays set.
- R11: Writes to mode, period high and period low are ignored while the timer runs.
- R12: `alt_tick` is never high in two cycles that are less than three cycles apart, which keeps the alternate source at no more than a third of the bus clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, applies read side effects |
| addr | input | 6 | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| alt_tick | input | 1 | Synchronous strobe of the alternate count source |
| irq | output | 1 | Level interrupt |

## Verification
The bench sweeps every divider value against several short periods and measures the cycles from the start to the interrupt. A design that counts one advance too few or too many, or that misapplies the divider, lands on a different cycle. It times the interval between continuous events and places a status read on the exact edge of an event. A design that lets the read win loses that interrupt. It also reads the count across a wrap of the low word with a delay between the two reads, which catches a design that returns the live high word instead of the captured one. Further checks cover configuration writes made while the timer runs, a period high write made without the matching low write, and an alternate source that is held idle. A design that leaks any of these changes a value the bench reads back.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;

  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL     = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE     = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_PER_LO   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_PER_HI   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI   = 6'h24;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_CLR_BIT  = 8;
  localparam int MODE_CONT_BIT = 0;
  localparam int MODE_ALT_BIT  = 3;
  localparam int MODE_DIV_LSB  = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MODE,
    SEL_PER_LO,
    SEL_PER_HI,
    SEL_IRQ_EN,
    SEL_IRQ_STAT,
    SEL_CNT_LO,
    SEL_CNT_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_CTRL:     decode_sel = SEL_CTRL;
      OFS_MODE:     decode_sel = SEL_MODE;
      OFS_PER_LO:   decode_sel = SEL_PER_LO;
      OFS_PER_HI:   decode_sel = SEL_PER_HI;
      OFS_IRQ_EN:   decode_sel = SEL_IRQ_EN;
      OFS_IRQ_STAT: decode_sel = SEL_IRQ_STAT;
      OFS_CNT_LO:   decode_sel = SEL_CNT_LO;
      OFS_CNT_HI:   decode_sel = SEL_CNT_HI;
      default:      decode_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tmr64_prescaler.sv
module tmr64_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             src_pulse,
  input  logic [PRE_W-1:0] div,
  output logic             advance
);

  logic [PRE_W-1:0] phase_q;
  logic             at_top;

  assign at_top  = (phase_q == div);
  assign advance = src_pulse && at_top && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clear) begin
      phase_q <= '0;
    end else if (src_pulse) begin
      if (at_top) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/tmr64_count.sv
module tmr64_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] count_q;

  assign count = count_q;
  assign hit   = advance && !clear && (count_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= '0;
    end else if (advance) begin
      if (count_q == limit) count_q <= '0;
      else                  count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
  import tmr64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              alt_tick,
  output logic              irq
);

  localparam int CNT_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              wr_ctrl, do_clr, do_go, cfg_open;
  logic              src_pulse, core_clear, adv, period_hit;
  logic              running_q, cont_q, alt_q, ie_q, flag_q;
  logic [PRE_W-1:0]  div_q;
  logic [CNT_W-1:0]  period_q, cnt_val;
  logic [DATA_W-1:0] per_hi_stage, hold_q;

  assign sel        = decode_sel(addr);
  assign wr_ctrl    = wr_en && (sel == SEL_CTRL);
  assign do_clr     = wr_ctrl && wdata[CTRL_CLR_BIT];
  assign do_go      = wr_ctrl && wdata[CTRL_GO_BIT] && !do_clr;
  assign cfg_open   = !running_q;
  assign core_clear = do_clr || do_go;
  assign src_pulse  = running_q && (alt_q ? alt_tick : 1'b1);

  tmr64_prescaler #(.PRE_W(PRE_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (core_clear),
    .src_pulse (src_pulse),
    .div       (div_q),
    .advance   (adv)
  );

  tmr64_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (core_clear),
    .advance (adv),
    .limit   (period_q),
    .count   (cnt_val),
    .hit     (period_hit)
  );

  // run state: clear beats start, start beats a one-shot stop
  always_ff @(posedge clk) begin
    if (!rst_n)                        running_q <= 1'b0;
    else if (do_clr)                   running_q <= 1'b0;
    else if (do_go)                    running_q <= 1'b1;
    else if (period_hit && !cont_q)    running_q <= 1'b0;
  end

  // configuration, locked while counting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont_q       <= 1'b0;
      alt_q        <= 1'b0;
      div_q        <= '0;
      period_q     <= '0;
      per_hi_stage <= '0;
    end else if (wr_en && cfg_open) begin
      case (sel)
        SEL_MODE: begin
          cont_q <= wdata[MODE_CONT_BIT];
          alt_q  <= wdata[MODE_ALT_BIT];
          div_q  <= wdata[MODE_DIV_LSB +: PRE_W];
        end
        SEL_PER_HI: per_hi_stage <= wdata;
        SEL_PER_LO: period_q     <= {per_hi_stage, wdata};
        default: ;
      endcase
    end
  end

  // interrupt enable, pending flag and count-high capture
  always_ff @(posedge clk) begin
    if (!rst_n || do_clr) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (wr_en && sel == SEL_IRQ_EN)
        ie_q <= wdata[0];
      if (period_hit)
        flag_q <= 1'b1;
      else if (rd_en && sel == SEL_IRQ_STAT)
        flag_q <= 1'b0;
      if (rd_en && sel == SEL_CNT_LO)
        hold_q <= cnt_val[CNT_W-1:DATA_W];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL:     rdata[0] = running_q;
      SEL_MODE: begin
        rdata[MODE_CONT_BIT]            = cont_q;
        rdata[MODE_ALT_BIT]             = alt_q;
        rdata[MODE_DIV_LSB +: PRE_W]    = div_q;
      end
      SEL_PER_LO:   rdata = period_q[DATA_W-1:0];
      SEL_PER_HI:   rdata = period_q[CNT_W-1:DATA_W];
      SEL_IRQ_EN:   rdata[0] = ie_q;
      SEL_IRQ_STAT: rdata[0] = flag_q;
      SEL_CNT_LO:   rdata = cnt_val[DATA_W-1:0];
      SEL_CNT_HI:   rdata = hold_q;
      default:      rdata = '0;
    endcase
  end

  assign irq = flag_q && ie_q;

endmodule

// File: rtl/tmr64_checker.sv
module tmr64_checker
  import tmr64_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int PRE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wdata_clr,
  input logic              alt_tick,
  input logic              irq,
  input logic              ie_q,
  input logic              flag_q,
  input logic              running_q,
  input logic              cont_q,
  input logic              period_hit,
  input logic [PRE_W-1:0]  div_q,
  input logic [CNT_W-1:0]  cnt_val,
  input logic [CNT_W-1:0]  period_q
);

  logic ctrl_wr, en_wr, stat_rd;
  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign en_wr   = wr_en && (addr == OFS_IRQ_EN);
  assign stat_rd = rd_en && (addr == OFS_IRQ_STAT);

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata_clr) |=> (!running_q && cnt_val == '0 && !irq)); // R1
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (cnt_val <= period_q)); // R3
  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && cont_q && !ctrl_wr) |=> (running_q && cnt_val == '0)); // R4
  AST_ONE_SHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && !cont_q && !ctrl_wr) |=> !running_q); // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && ie_q && !ctrl_wr && !en_wr) |=> irq); // R9
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !period_hit) |=> !flag_q); // R10
  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && period_hit && !ctrl_wr) |=> flag_q); // R10
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |=> ($stable(period_q) && $stable(div_q) && $stable(cont_q))); // R11
  AST_ALT_GAP1: assert property (@(posedge clk) disable iff (!rst_n)
    alt_tick |=> !alt_tick); // R12
  AST_ALT_GAP2: assert property (@(posedge clk) disable iff (!rst_n)
    alt_tick |-> ##2 !alt_tick); // R12

endmodule

bind interval_timer64 tmr64_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata_clr  (wdata[8]),
  .alt_tick   (alt_tick),
  .irq        (irq),
  .ie_q       (ie_q),
  .flag_q     (flag_q),
  .running_q  (running_q),
  .cont_q     (cont_q),
  .period_hit (period_hit),
  .div_q      (div_q),
  .cnt_val    (cnt_val),
  .period_q   (period_q)
);

// File: tb/tb_interval_timer64.sv
`timescale 1ns/1ps
module tb_interval_timer64;
  import tmr64_pkg::*;

  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          alt_tick = 1'b0;
  logic          irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_rd_cyc = 0;
  bit done = 1'b0;

  interval_timer64 #(.DATA_W(DW), .PRE_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alt_tick(alt_tick), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    last_rd_cyc = cyc;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cfg_run(input bit cont, input bit alt, input int dv,
                         input logic [2*DW-1:0] per, input bit ie);
    wr(OFS_CTRL, 12'h100);
    wr(OFS_MODE, DW'((dv << 8) | (int'(alt) << 3) | int'(cont)));
    wr(OFS_PER_HI, per[2*DW-1:DW]);
    wr(OFS_PER_LO, per[DW-1:0]);
    wr(OFS_IRQ_EN, DW'(ie));
    wr(OFS_CTRL, 12'h001);
  endtask

  task automatic wait_irq(inout int c);
    while (!irq && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, lo, hi;
    int c, c0, pulses, ph, te;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2: reset state of every register
    chk("R1 irq after reset", irq, 0);
    rd(OFS_CTRL, d);     chk("R1 ctrl reset", d, 0);
    rd(OFS_MODE, d);     chk("R1 mode reset", d, 0);
    rd(OFS_PER_LO, d);   chk("R1 period lo reset", d, 0);
    rd(OFS_IRQ_EN, d);   chk("R2 irq enable reset", d, 0);
    rd(OFS_IRQ_STAT, d); chk("R2 status reset", d, 0);
    rd(OFS_CNT_LO, d);   chk("R2 count lo reset", d, 0);

    // R3, R5: sweep every divider over short periods, one-shot
    for (int dv = 0; dv < 16; dv++) begin
      for (int n = 0; n < 4; n++) begin
        cfg_run(1'b0, 1'b0, dv, (2*DW)'(n), 1'b1);
        c = 0;
        wait_irq(c);
        chk($sformatf("R3 first event d=%0d n=%0d", dv, n), c, (dv+1)*(n+1));
        rd(OFS_CTRL, d);   chk("R5 one-shot stopped", d, 0);
        rd(OFS_CNT_LO, d); chk("R5 one-shot count zero", d, 0);
      end
    end

    // R4, R10: continuous repeat, clear by read, read on event edge
    cfg_run(1'b1, 1'b0, 0, 24'd9, 1'b1);
    c = 0;
    wait_irq(c);
    chk("R3 continuous first event", c, 10);
    rd(OFS_IRQ_STAT, d);
    chk("R10 status read value", d, 1);
    chk("R10 irq low after status read", irq, 0);
    c = 2;
    wait_irq(c);
    chk("R4 continuous period", c, 10);
    te = cyc;
    while (cyc < te + 8) @(negedge clk);
    rd(OFS_IRQ_STAT, d);
    chk("R10 event on read edge keeps flag", irq, 1);
    rd(OFS_IRQ_STAT, d);
    chk("R10 second read clears", irq, 0);

    // R11: configuration locked while running
    cfg_run(1'b1, 1'b0, 0, 24'd1000, 1'b0);
    wr(OFS_PER_LO, 12'd5);
    rd(OFS_PER_LO, d); chk("R11 period write ignored", d, 1000);
    wr(OFS_MODE, 12'h000);
    rd(OFS_MODE, d);   chk("R11 mode write ignored", d, 1);

    // R1: software clear while running keeps mode and period
    wr(OFS_IRQ_EN, 12'd1);
    rd(OFS_CNT_LO, d);
    wr(OFS_CTRL, 12'h101);
    rd(OFS_CTRL, d);     chk("R1 clear beats start", d, 0);
    rd(OFS_IRQ_EN, d);   chk("R1 enable cleared", d, 0);
    rd(OFS_CNT_LO, d);   chk("R1 count cleared", d, 0);
    rd(OFS_CNT_HI, d);   chk("R1 hold cleared", d, 0);
    rd(OFS_MODE, d);     chk("R1 mode kept", d, 1);
    rd(OFS_PER_LO, d);   chk("R1 period kept", d, 1000);

    // R7: staged high word
    wr(OFS_PER_HI, 12'd3);
    rd(OFS_PER_HI, d); chk("R7 high staged only", d, 0);
    wr(OFS_PER_LO, 12'd7);
    rd(OFS_PER_HI, d); chk("R7 high after low write", d, 3);
    rd(OFS_PER_LO, d); chk("R7 low after low write", d, 7);

    // R9: event with enable clear, then enable
    cfg_run(1'b0, 1'b0, 0, 24'd3, 1'b0);
    repeat (20) @(negedge clk);
    chk("R9 irq masked", irq, 0);
    wr(OFS_IRQ_EN, 12'd1);
    chk("R9 irq after enable", irq, 1);
    rd(OFS_IRQ_STAT, d);
    chk("R9 flag was pending", d, 1);

    // R8: coherent count across the low-word wrap
    cfg_run(1'b1, 1'b0, 0, 24'hFFFFFF, 1'b0);
    c0 = cyc;
    while (cyc - c0 < 4090) @(negedge clk);
    rd(OFS_CNT_LO, lo);
    te = last_rd_cyc - c0;
    repeat (12) @(negedge clk);
    rd(OFS_CNT_HI, hi);
    chk("R8 coherent before wrap", {hi, lo}, te);
    repeat (30) @(negedge clk);
    rd(OFS_CNT_LO, lo);
    te = last_rd_cyc - c0;
    repeat (7) @(negedge clk);
    rd(OFS_CNT_HI, hi);
    chk("R8 coherent after wrap", {hi, lo}, te);

    // R6, R12: alternate source, idle then spaced strobes
    cfg_run(1'b0, 1'b1, 1, 24'd2, 1'b1);
    repeat (30) @(negedge clk);
    rd(OFS_CNT_LO, d);
    chk("R6 no advance without strobe", d, 0);
    pulses = 0; ph = 0; c = 0;
    while (!irq && c < 500) begin
      @(negedge clk);
      if (irq) break;
      alt_tick = (ph == 0);
      if (alt_tick) pulses++;
      ph = (ph + 1) % 3;
      c++;
    end
    alt_tick = 1'b0;
    chk("R6 strobes to event", pulses, 6);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule